// File: doc/BRIEF.md
# Chained Debug Register Node

This block is one stage in a series of debug cores that share a narrow register bus. Each stage takes a bus transaction (address, a 32-bit data field, a write/read selector, a transaction-valid flag and a read-response flag) from the stage before it. It registers the transaction and hands it to the stage after it. Every path therefore runs between two neighbouring stages only, and a transaction needs one clock per stage to cross the chain.

Each stage owns a contiguous window of register addresses that starts at a parameter base. The next stage's base is this base plus this stage's register count. The lower part of the window holds registers that the host can write, and their contents drive the core logic behind the node. The upper part holds read-only words that the core supplies. A read that hits the window puts the addressed word in the data field and raises the read-response flag. Reads and writes that miss the window pass through untouched. A read that no stage claims reaches the end of the chain with the flag still low.

Top module: `dbg_chain_node`

## Requirements
- R1: `out_addr`, `out_rw` and `out_valid` equal `in_addr`, `in_rw` and `in_valid` from exactly one clock earlier.
- R2: While `rst` is high at a clock edge, `out_valid` and `out_rvalid` go low and every writable register clears to zero, so `ctrl_out` reads zero.
- R3: The node owns addresses BASE to BASE+N_RW+N_RO-1. Offset = address − BASE. Offsets 0..N_RW-1 are writable registers, and offsets N_RW and up are the read-only words, with word j taken from `ro_in[32*j+31:32*j]`.
- R4: A valid write (`in_rw`=1) to a writable offset k stores `in_data` in register k. From the next clock, `ctrl_out[32*k+31:32*k]` shows the new value.
- R5: A valid write to a read-only offset changes no register: `ctrl_out` stays the same, and a later read of that offset still returns `ro_in`.
- R6: A valid read (`in_rw`=0) that hits the window sets `out_data` to the addressed word one clock later: the stored register, or `ro_in` as it was when the request was captured. It also sets `out_rvalid` to 1.
- R7: A transaction outside the window, or any cycle with `in_valid`=0, forwards `in_data` to `out_data` and `in_rvalid` to `out_rvalid` unchanged, and changes no register.
- R8: A valid write, whether it hits or misses, forwards `in_data` to `out_data` and `in_rvalid` to `out_rvalid`, so a write never produces a read response.
- R9: With default parameters the address width is the smallest width that covers CHAIN_REGS locations (4 bits for 16). The address width never exceeds 8 bits.
- R10: A write-shaped transaction with `in_valid`=0 whose address falls on a writable offset leaves `ctrl_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_addr | input | ADDR_W | Address from the previous stage |
| in_data | input | 32 | Write data or in-flight read data from the previous stage |
| in_rw | input | 1 | 1 = write, 0 = read |
| in_valid | input | 1 | Transaction present |
| in_rvalid | input | 1 | Read response already attached upstream |
| ro_in | input | 32*N_RO | Read-only words supplied by the core |
| out_addr | output | ADDR_W | Registered address to the next stage |
| out_data | output | 32 | Registered data field to the next stage |
| out_rw | output | 1 | Registered write/read selector |
| out_valid | output | 1 | Registered transaction-valid flag |
| out_rvalid | output | 1 | Registered read-response flag |
| ctrl_out | output | 32*N_RW | Contents of the writable registers |

## Verification
The hardest cases to reach from the ports are writes that must leave no trace. A write aimed at a read-only word, or a write carried on a cycle with the valid flag low, changes no output in its own cycle. The stimulus follows each such write with a read of the same offset and keeps checking `ctrl_out` every cycle, so a wrongly stored value shows up. Directed cases cover the addresses at both window edges and at the boundary between the writable and read-only parts. A long random run then mixes reads, writes, idle cycles and stray read-response flags over the whole address space.

// File: rtl/dbg_node_pkg.sv
package dbg_node_pkg;
  localparam int REG_W      = 32;
  localparam int MAX_ADDR_W = 8;

  typedef enum logic {
    BUS_READ  = 1'b0,
    BUS_WRITE = 1'b1
  } bus_op_e;

  // Smallest address width covering n locations.
  function automatic int addr_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dbg_addr_window.sv
module dbg_addr_window #(
  parameter int ADDR_W = 4,
  parameter int BASE   = 0,
  parameter int N_RW   = 4,
  parameter int N_RO   = 4,
  parameter int OFF_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  output logic              hit,
  output logic              writable,
  output logic [OFF_W-1:0]  off
);
  localparam int TOTAL = N_RW + N_RO;

  logic [31:0] rel;

  // Below-base addresses wrap to a large value and fall out of range.
  assign rel      = 32'(addr) - 32'(BASE);
  assign hit      = valid && (rel < 32'(TOTAL));
  assign writable = hit && (rel < 32'(N_RW));
  assign off      = rel[OFF_W-1:0];
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank #(
  parameter int N_RW  = 4,
  parameter int N_RO  = 4,
  parameter int OFF_W = 3,
  parameter int RW_IW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [RW_IW-1:0]    wr_idx,
  input  logic [31:0]         wdata,
  input  logic [OFF_W-1:0]    rd_off,
  input  logic [32*N_RO-1:0]  ro_in,
  output logic [31:0]         rd_word,
  output logic [32*N_RW-1:0]  ctrl_out
);
  localparam int TOTAL = N_RW + N_RO;

  logic [31:0] mem   [N_RW];
  logic [31:0] words [TOTAL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_RW; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_RW; g++) begin : g_rw
      assign words[g]              = mem[g];
      assign ctrl_out[32*g +: 32]  = mem[g];
    end
    for (g = 0; g < N_RO; g++) begin : g_ro
      assign words[N_RW+g] = ro_in[32*g +: 32];
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (32'(rd_off) < 32'(TOTAL)) rd_word = words[rd_off];
  end

  // R4: a write lands in the addressed register
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wr_idx)] == $past(wdata));
endmodule

// File: rtl/dbg_fwd_stage.sv
module dbg_fwd_stage #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [31:0]       in_data,
  input  logic              in_rw,
  input  logic              in_valid,
  input  logic              in_rvalid,
  input  logic              rd_sel,
  input  logic [31:0]       rd_word,
  output logic [ADDR_W-1:0] out_addr,
  output logic [31:0]       out_data,
  output logic              out_rw,
  output logic              out_valid,
  output logic              out_rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr   <= '0;
      out_data   <= '0;
      out_rw     <= 1'b0;
      out_valid  <= 1'b0;
      out_rvalid <= 1'b0;
    end else begin
      out_addr  <= in_addr;
      out_rw    <= in_rw;
      out_valid <= in_valid;
      if (rd_sel) begin
        out_data   <= rd_word;
        out_rvalid <= 1'b1;
      end else begin
        out_data   <= in_data;
        out_rvalid <= in_rvalid;
      end
    end
  end

  // R1: control fields are delayed by exactly one clock
  assert_fwd_delay_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)) && (out_addr == $past(in_addr))
             && (out_rw == $past(in_rw)));
endmodule

// File: rtl/dbg_chain_node.sv
module dbg_chain_node #(
  parameter int CHAIN_REGS = 16,
  parameter int BASE       = 4,
  parameter int N_RW       = 4,
  parameter int N_RO       = 4,
  parameter int ADDR_W     = dbg_node_pkg::addr_bits(CHAIN_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [31:0]         in_data,
  input  logic                in_rw,
  input  logic                in_valid,
  input  logic                in_rvalid,
  input  logic [32*N_RO-1:0]  ro_in,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [31:0]         out_data,
  output logic                out_rw,
  output logic                out_valid,
  output logic                out_rvalid,
  output logic [32*N_RW-1:0]  ctrl_out
);
  import dbg_node_pkg::*;

  localparam int TOTAL = N_RW + N_RO;
  localparam int OFF_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int RW_IW = (N_RW > 1) ? $clog2(N_RW) : 1;

  logic             hit, writable, we, rd_sel;
  logic [OFF_W-1:0] off;
  logic [31:0]      rd_word;

  // R9: address width fits the chain and the one-byte bus
  initial begin
    assert_addr_fit_R9: assert ((ADDR_W <= MAX_ADDR_W) && ((1 << ADDR_W) >= CHAIN_REGS)
                                && (BASE + TOTAL <= CHAIN_REGS))
      else $error("address window does not fit the bus");
  end

  dbg_addr_window #(
    .ADDR_W(ADDR_W), .BASE(BASE), .N_RW(N_RW), .N_RO(N_RO), .OFF_W(OFF_W)
  ) u_win (
    .addr(in_addr), .valid(in_valid), .hit(hit), .writable(writable), .off(off)
  );

  assign we     = writable && (in_rw == BUS_WRITE);
  assign rd_sel = hit && (in_rw == BUS_READ);

  dbg_reg_bank #(
    .N_RW(N_RW), .N_RO(N_RO), .OFF_W(OFF_W), .RW_IW(RW_IW)
  ) u_bank (
    .clk(clk), .rst(rst), .we(we), .wr_idx(off[RW_IW-1:0]), .wdata(in_data),
    .rd_off(off), .ro_in(ro_in), .rd_word(rd_word), .ctrl_out(ctrl_out)
  );

  dbg_fwd_stage #(.ADDR_W(ADDR_W)) u_fwd (
    .clk(clk), .rst(rst),
    .in_addr(in_addr), .in_data(in_data), .in_rw(in_rw),
    .in_valid(in_valid), .in_rvalid(in_rvalid),
    .rd_sel(rd_sel), .rd_word(rd_word),
    .out_addr(out_addr), .out_data(out_data), .out_rw(out_rw),
    .out_valid(out_valid), .out_rvalid(out_rvalid)
  );

  // R2: reset clears the valid flags and the writable registers
  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> !out_valid && !out_rvalid && (ctrl_out == '0));

  // R5: writes to read-only words leave the registers alone
  assert_ro_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && in_rw && !writable) |=> $stable(ctrl_out));

  // R6: a read hit raises the response flag
  assert_read_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && !in_rw) |=> out_rvalid);

  // R7: a miss passes data and flag through
  assert_miss_pass_R7: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (out_data == $past(in_data)) && (out_rvalid == $past(in_rvalid)));

  // R8: a write never attaches a read response
  assert_write_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rw) |=> (out_data == $past(in_data)) && (out_rvalid == $past(in_rvalid)));

  // R10: idle cycles never write
  assert_idle_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ctrl_out));
endmodule

// File: tb/tb_dbg_chain_node.sv
module tb_dbg_chain_node;
  localparam int CLK_PERIOD = 10;
  localparam int CHAIN_REGS = 16;
  localparam int BASE       = 4;
  localparam int N_RW       = 4;
  localparam int N_RO       = 4;
  localparam int AW         = 4;
  localparam int TOTAL      = N_RW + N_RO;

  logic              clk = 1'b0;
  logic              rst;
  logic [AW-1:0]     in_addr;
  logic [31:0]       in_data;
  logic              in_rw, in_valid, in_rvalid;
  logic [32*N_RO-1:0] ro_in;
  logic [AW-1:0]     out_addr;
  logic [31:0]       out_data;
  logic              out_rw, out_valid, out_rvalid;
  logic [32*N_RW-1:0] ctrl_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model [N_RW];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_chain_node #(.CHAIN_REGS(CHAIN_REGS), .BASE(BASE), .N_RW(N_RW), .N_RO(N_RO)) dut (
    .clk(clk), .rst(rst), .in_addr(in_addr), .in_data(in_data), .in_rw(in_rw),
    .in_valid(in_valid), .in_rvalid(in_rvalid), .ro_in(ro_in),
    .out_addr(out_addr), .out_data(out_data), .out_rw(out_rw),
    .out_valid(out_valid), .out_rvalid(out_rvalid), .ctrl_out(ctrl_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_window(input logic [AW-1:0] a);
    return (int'(a) >= BASE) && (int'(a) < BASE + TOTAL);
  endfunction

  task automatic check_ctrl(input string req);
    for (int i = 0; i < N_RW; i++) check(req, ctrl_out[32*i +: 32], model[i]);
  endtask

  // One transaction: drive at the falling edge, sample at the next falling edge.
  task automatic xfer(input logic [AW-1:0] a, input logic [31:0] d, input logic rw,
                      input logic v, input logic rv);
    logic [31:0] exp_d;
    logic        exp_rv;
    bit          hit;
    int          off;
    string       tag;
    in_addr = a; in_data = d; in_rw = rw; in_valid = v; in_rvalid = rv;
    hit = v && in_window(a);
    off = int'(a) - BASE;
    if (hit && !rw) begin
      exp_d  = (off < N_RW) ? model[off] : ro_in[32*(off-N_RW) +: 32];
      exp_rv = 1'b1;
      tag    = "R6 read hit";
    end else begin
      exp_d  = d;
      exp_rv = rv;
      tag    = rw ? (v ? "R8 write forward" : "R10 idle write") : "R7 miss";
    end
    @(posedge clk);
    @(negedge clk);
    if (hit && rw && off < N_RW) model[off] = d;
    check("R1 addr", 32'(out_addr), 32'(a));
    check("R1 rw/valid", {30'd0, out_rw, out_valid}, {30'd0, rw, v});
    check(tag, out_data, exp_d);
    check({tag, " flag"}, 32'(out_rvalid), 32'(exp_rv));
    if (hit && rw && off >= N_RW) check_ctrl("R5 ro write");
    else if (!v)                   check_ctrl("R10 idle");
    else                           check_ctrl("R4 ctrl");
  endtask

  task automatic do_reset();
    in_valid = 1'b1; in_rvalid = 1'b1; in_rw = 1'b1; in_addr = AW'(BASE); in_data = '1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N_RW; i++) model[i] = '0;
    check("R2 valid", 32'(out_valid), 32'd0);
    check("R2 rvalid", 32'(out_rvalid), 32'd0);
    check_ctrl("R2 ctrl");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    ro_in = {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};
    @(negedge clk);
    do_reset();
    check("R9 addr width", $bits(dut.out_addr), AW);

    // R3 / R4: both ends of the writable part
    xfer(AW'(BASE), 32'hAAAA_0001, 1'b1, 1'b1, 1'b0);
    xfer(AW'(BASE+N_RW-1), 32'hBBBB_0002, 1'b1, 1'b1, 1'b0);
    xfer(AW'(BASE), 32'h0, 1'b0, 1'b1, 1'b0);
    xfer(AW'(BASE+N_RW-1), 32'h0, 1'b0, 1'b1, 1'b0);
    // R5: write to first read-only word, then read it back
    xfer(AW'(BASE+N_RW), 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0);
    xfer(AW'(BASE+N_RW), 32'h1234_5678, 1'b0, 1'b1, 1'b0);
    // R3: last word of the window is read-only
    xfer(AW'(BASE+TOTAL-1), 32'h0, 1'b0, 1'b1, 1'b0);
    // R7: just below and just above the window
    xfer(AW'(BASE-1), 32'h5555_AAAA, 1'b0, 1'b1, 1'b1);
    xfer(AW'(BASE-1), 32'h7777_0000, 1'b1, 1'b1, 1'b0);
    xfer(AW'(BASE+TOTAL), 32'h0BAD_F00D, 1'b0, 1'b1, 1'b0);
    // R10: write-shaped idle cycle on a writable offset
    xfer(AW'(BASE+1), 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    xfer(AW'(BASE+1), 32'h0, 1'b0, 1'b1, 1'b0);
    // R8: write carrying a stray response flag
    xfer(AW'(BASE+2), 32'h3333_3333, 1'b1, 1'b1, 1'b1);

    for (int n = 0; n < 3000; n++) begin
      for (int j = 0; j < N_RO; j++) ro_in[32*j +: 32] = $urandom;
      xfer(AW'($urandom_range(CHAIN_REGS-1)), $urandom, 1'($urandom),
           ($urandom_range(9) < 8), 1'($urandom));
      if (n == 1500) do_reset();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule